// File: doc/BRIEF.md
# Trimmed Seconds Timebase

This block is the seconds stage of a real-time clock. It runs on the 32.768 kHz crystal clock, one input cycle per clock edge. A 16-bit prescaler counts up to a terminal value and then returns to zero. Each such wrap produces a single-cycle one-second tick and advances a two-digit BCD seconds counter. The counter runs from 00 to 59 and then wraps, and that wrap raises a minute carry for the next stage. With no trim, the terminal value is 7FFFH, so every second lasts exactly 32768 input cycles.

A crystal that runs slow or fast is corrected with an 8-bit trim byte, loaded through a one-cycle write strobe. The trim lengthens or shortens selected seconds by an even number of input cycles. A mode bit picks which seconds are corrected: 00, 20 and 40, or 00 alone. The adjusted terminal value is captured when the prescaler wraps into a correcting second, so a trim write never disturbs the second already running. A write that arrives during a second that may be corrected still takes effect, but it also sets a sticky violation flag, which software clears with a dedicated input.

Top module: `rtc_trim_timebase`

## Requirements
- R1: After reset the trim byte is 00H, the seconds value is 00, the tick, carry and violation outputs are low, and the first second lasts REF_TC+1 cycles.
- R2: `sec_tick` is a single-cycle pulse. It is high in the cycle where the prescaler reaches the terminal value latched for the current second, and it repeats every terminal+1 cycles. An uncorrected second uses REF_TC (default 7FFFH).
- R3: `sec_bcd` holds the tens digit in bits [7:4] and the units digit in bits [3:0]. It advances by one at each tick through 00..59, and neither digit ever leaves its valid range.
- R4: `min_carry` is high exactly in the tick cycle in which `sec_bcd` is 59, after which `sec_bcd` becomes 00.
- R5: A cycle with `wr_en` high loads the whole of `wr_data` into the trim byte at that clock edge. Bit 7 is the mode bit, bit 6 is the direction bit and bits [5:0] are the magnitude field F.
- R6: With direction 0 and F nonzero, a correcting second lasts REF_TC+1+2*(F-1) cycles.
- R7: With direction 1 and F nonzero, a correcting second lasts REF_TC+1-2*((~F)+1) cycles, that is REF_TC+1-2*(64-F).
- R8: With F equal to 000000, no second is corrected, whatever the direction and mode bits hold.
- R9: Mode bit 0 makes the seconds 00, 20 and 40 correcting seconds. Mode bit 1 makes only second 00 a correcting second. All other seconds last REF_TC+1 cycles.
- R10: The terminal value of a second is fixed by the trim byte present at the wrap that starts it. A write made during a second does not change the length of that second.
- R11: A write made while the current seconds value is a correcting second, under the mode bit stored before the write, sets `wr_violation`, and the written byte is still loaded. A write made in any other second leaves the flag unchanged.
- R12: With no violating write in the same cycle, a high `viol_clr` clears `wr_violation` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock, one prescaler step per edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle strobe that loads the trim byte |
| wr_data | input | 8 | Trim byte: [7] mode, [6] direction, [5:0] magnitude |
| viol_clr | input | 1 | Clears the sticky write-violation flag |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| sec_bcd | output | 8 | Seconds in BCD, tens in [7:4] and units in [3:0] |
| min_carry | output | 1 | One-cycle pulse on the 59-to-00 wrap |
| wr_violation | output | 1 | Sticky flag: a trim write landed in a correcting second |

## Verification
The hardest case to reach from the ports is a trim write that lands exactly before the wrap into a correcting second. The same case appears as a write made inside a correcting second, where the old and new trim values must each govern their own second. The bench shrinks the reference terminal value, so a whole minute takes a few thousand cycles. It waits on the BCD output for chosen seconds (19, 39, 59 and the correcting seconds themselves) before it strobes a new trim byte. A cycle-accurate model in the bench then predicts every second's length, each tick and carry position, and the violation flag.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    localparam int TRIM_W  = 8;
    localparam int FIELD_W = 6;

    typedef struct packed {
        logic               dev;      // 1: only second 00 corrects
        logic               shorten;  // direction bit
        logic [FIELD_W-1:0] mag;      // magnitude field
    } trim_t;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd_sec_t;

    // True when the given seconds value is one in which correction applies.
    function automatic logic is_corr_sec(input bcd_sec_t s, input logic dev);
        logic on_zero;
        logic on_twenty;
        on_zero   = (s.ones == 4'd0) && (s.tens == 4'd0);
        on_twenty = (s.ones == 4'd0) && ((s.tens == 4'd2) || (s.tens == 4'd4));
        return on_zero || (!dev && on_twenty);
    endfunction

endpackage

// File: rtl/rtc_trim_calc.sv
module rtc_trim_calc
    import rtc_trim_pkg::*;
#(
    parameter int                    PRESCALE_W = 16,
    parameter logic [PRESCALE_W-1:0] REF_TC     = 16'h7FFF
) (
    input  trim_t                 trim,
    output logic [PRESCALE_W-1:0] corr_tc,
    output logic                  corr_en
);

    localparam int STEP_W = FIELD_W + 1;
    localparam int AMT_W  = STEP_W + 1;

    logic [STEP_W-1:0]     step_long;
    logic [STEP_W-1:0]     step_short;
    logic [STEP_W-1:0]     step_sel;
    logic [AMT_W-1:0]      amount;
    logic [PRESCALE_W-1:0] amount_ext;

    always_comb begin
        step_long  = {1'b0, trim.mag} - STEP_W'(1);
        step_short = {1'b0, ~trim.mag} + STEP_W'(1);
        step_sel   = trim.shorten ? step_short : step_long;
        amount     = {step_sel, 1'b0};
        amount_ext = PRESCALE_W'(amount);
        corr_en    = (trim.mag != '0);
        corr_tc    = trim.shorten ? (REF_TC - amount_ext) : (REF_TC + amount_ext);
    end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int                    PRESCALE_W = 16,
    parameter logic [PRESCALE_W-1:0] REF_TC     = 16'h7FFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRESCALE_W-1:0] next_tc,
    output logic                  tick
);

    typedef struct packed {
        logic [PRESCALE_W-1:0] cnt;
        logic [PRESCALE_W-1:0] tc;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == st_q.tc);
        if (tick) begin
            st_d.cnt = '0;
            st_d.tc  = next_tc;
        end else begin
            st_d.cnt = st_q.cnt + PRESCALE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.tc  <= REF_TC;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.tc);

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0));

    // R10
    tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.tc));

endmodule

// File: rtl/rtc_sec_bcd.sv
module rtc_sec_bcd
    import rtc_trim_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    output bcd_sec_t sec,
    output bcd_sec_t sec_next,
    output logic     wrap
);

    bcd_sec_t sec_d, sec_q;
    logic     last_sec;

    always_comb begin
        last_sec = (sec_q.tens == 4'd5) && (sec_q.ones == 4'd9);
        sec_next = sec_q;
        if (sec_q.ones == 4'd9) begin
            sec_next.ones = 4'd0;
            sec_next.tens = last_sec ? 4'd0 : sec_q.tens + 4'd1;
        end else begin
            sec_next.ones = sec_q.ones + 4'd1;
        end
        sec_d = adv ? sec_next : sec_q;
        wrap  = adv && last_sec;
        sec   = sec_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sec_q <= '0;
        else        sec_q <= sec_d;
    end

    // R3
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q.ones <= 4'd9) && (sec_q.tens <= 4'd5));

    // R4
    carry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (sec_q == '0));

    // R3
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(sec_q));

endmodule

// File: rtl/rtc_trim_timebase.sv
module rtc_trim_timebase
    import rtc_trim_pkg::*;
#(
    parameter int                    PRESCALE_W = 16,
    parameter logic [PRESCALE_W-1:0] REF_TC     = 16'h7FFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       viol_clr,
    output logic       sec_tick,
    output logic [7:0] sec_bcd,
    output logic       min_carry,
    output logic       wr_violation
);

    typedef struct packed {
        trim_t trim;
        logic  viol;
    } ctl_state_t;

    ctl_state_t            ctl_d, ctl_q;
    logic [PRESCALE_W-1:0] corr_tc;
    logic                  corr_en;
    logic [PRESCALE_W-1:0] next_tc;
    logic                  tick;
    bcd_sec_t              sec_cur;
    bcd_sec_t              sec_nxt;
    logic                  wrap;
    logic                  in_prohib;

    rtc_trim_calc #(
        .PRESCALE_W (PRESCALE_W),
        .REF_TC     (REF_TC)
    ) u_calc (
        .trim    (ctl_q.trim),
        .corr_tc (corr_tc),
        .corr_en (corr_en)
    );

    rtc_prescaler #(
        .PRESCALE_W (PRESCALE_W),
        .REF_TC     (REF_TC)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .next_tc (next_tc),
        .tick    (tick)
    );

    rtc_sec_bcd u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (tick),
        .sec      (sec_cur),
        .sec_next (sec_nxt),
        .wrap     (wrap)
    );

    always_comb begin
        in_prohib = is_corr_sec(sec_cur, ctl_q.trim.dev);
        next_tc   = (corr_en && is_corr_sec(sec_nxt, ctl_q.trim.dev)) ? corr_tc : REF_TC;

        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.trim = trim_t'(wr_data);
        end
        if (wr_en && in_prohib) begin
            ctl_d.viol = 1'b1;
        end else if (viol_clr) begin
            ctl_d.viol = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sec_tick     = tick;
    assign sec_bcd      = sec_cur;
    assign min_carry    = wrap;
    assign wr_violation = ctl_q.viol;

    // R5
    trim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q.trim == trim_t'($past(wr_data))));

    // R11
    viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_prohib) |=> wr_violation);

    // R12
    viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_clr && !(wr_en && in_prohib)) |=> !wr_violation);

    // R4
    carry_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        min_carry |-> (sec_tick && (sec_bcd == 8'h59)));

endmodule

// File: tb/rtc_trim_timebase_tb.sv
module rtc_trim_timebase_tb;

    localparam int         REF = 127;
    localparam logic [15:0] REF_TC = 16'(REF);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       viol_clr = 1'b0;
    logic       sec_tick;
    logic [7:0] sec_bcd;
    logic       min_carry;
    logic       wr_violation;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    rtc_trim_timebase #(
        .PRESCALE_W (16),
        .REF_TC     (REF_TC)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .viol_clr     (viol_clr),
        .sec_tick     (sec_tick),
        .sec_bcd      (sec_bcd),
        .min_carry    (min_carry),
        .wr_violation (wr_violation)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic bit corr_sec(input logic [7:0] s, input bit dev);
        int v;
        v = int'(s[7:4]) * 10 + int'(s[3:0]);
        return (v == 0) || (!dev && (v == 20 || v == 40));
    endfunction

    function automatic int sec_len(input logic [7:0] s, input logic [7:0] t);
        int f;
        f = int'(t[5:0]);
        if (f == 0 || !corr_sec(s, t[7])) return REF + 1;
        if (!t[6]) return REF + 1 + 2 * (f - 1);
        return REF + 1 - 2 * (64 - f);
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] s);
        int v;
        v = (int'(s[7:4]) * 10 + int'(s[3:0]) + 1) % 60;
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // Reference model, evaluated away from the active edge.
    logic [7:0] m_sec  = 8'h00;
    logic [7:0] m_trim = 8'h00;
    bit         m_viol = 1'b0;
    int         m_len  = REF + 1;
    int         m_cyc  = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_tick;
            bit nxt_viol;
            m_cyc++;
            exp_tick = (m_cyc == m_len);
            check(sec_tick == exp_tick, "R2/R6/R7/R8/R9/R10 tick", int'(sec_tick), int'(exp_tick));
            check(sec_bcd == m_sec, "R3 seconds", int'(sec_bcd), int'(m_sec));
            check(min_carry == (exp_tick && m_sec == 8'h59), "R4 carry",
                  int'(min_carry), int'(exp_tick && m_sec == 8'h59));
            check(wr_violation == m_viol, "R11/R12 flag", int'(wr_violation), int'(m_viol));
            nxt_viol = m_viol;
            if (wr_en && corr_sec(m_sec, m_trim[7])) nxt_viol = 1'b1;
            else if (viol_clr) nxt_viol = 1'b0;
            if (exp_tick) begin
                m_sec = bcd_inc(m_sec);
                m_len = sec_len(m_sec, m_trim);
                m_cyc = 0;
            end
            if (wr_en) m_trim = wr_data;
            m_viol = nxt_viol;
        end
    end

    task automatic write_at(input logic [7:0] target, input logic [7:0] val);
        do begin @(posedge clk); #1; end while (sec_bcd == target);
        do begin @(posedge clk); #1; end while (sec_bcd != target);
        wr_en   = 1'b1;
        wr_data = val;
        @(posedge clk); #1;
        wr_en   = 1'b0;
    endtask

    task automatic clear_flag();
        @(posedge clk); #1;
        viol_clr = 1'b1;
        @(posedge clk); #1;
        viol_clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    logic [7:0] list0 [15] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h20, 8'h3F, 8'h41, 8'h42,
                               8'h7F, 8'h7E, 8'h60, 8'h40, 8'h5F, 8'h21, 8'h3E};
    logic [7:0] list1 [5]  = '{8'h82, 8'hBF, 8'hC1, 8'hFF, 8'h80};

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(sec_bcd == 8'h00, "R1 seconds", int'(sec_bcd), 0);
        check(sec_tick == 1'b0, "R1 tick", int'(sec_tick), 0);
        check(min_carry == 1'b0, "R1 carry", int'(min_carry), 0);
        check(wr_violation == 1'b0, "R1 flag", int'(wr_violation), 0);
        rst_n = 1'b1;

        // R5 R6 R7 R8 R9: mode 0, writes just before each correcting second
        for (int i = 0; i < 15; i++) begin
            logic [7:0] tgt;
            tgt = (i % 3 == 0) ? 8'h19 : (i % 3 == 1) ? 8'h39 : 8'h59;
            write_at(tgt, list0[i]);
        end
        // R9: mode 1, seconds 20 and 40 stay uncorrected
        for (int i = 0; i < 5; i++) begin
            write_at(8'h59, list1[i]);
            write_at(8'h41, list1[i]);
        end

        // R10 R11: write inside correcting second 00 (mode 1 stored)
        write_at(8'h59, 8'h85);
        write_at(8'h00, 8'h00);
        @(negedge clk);
        check(wr_violation == 1'b1, "R11 set in second 00", int'(wr_violation), 1);
        // R12
        write_at(8'h05, 8'h00);
        clear_flag();
        @(negedge clk);
        check(wr_violation == 1'b0, "R12 cleared", int'(wr_violation), 0);
        // R11: mode 0 stored, second 20 is prohibited, byte still loads
        write_at(8'h20, 8'h0A);
        @(negedge clk);
        check(wr_violation == 1'b1, "R11 set in second 20", int'(wr_violation), 1);
        clear_flag();
        // R11: write in a non-correcting second leaves flag low
        write_at(8'h21, 8'hAA);
        @(negedge clk);
        check(wr_violation == 1'b0, "R11 untouched in second 21", int'(wr_violation), 0);
        // let second 00 with +82 run out
        write_at(8'h02, 8'hAA);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule